// File: doc/BRIEF.md
# Serial Interrupt Host Controller

This block sits at the host end of a single shared interrupt wire. The wire is open-drain with a pull-up. Peripherals report their interrupt levels on it one after another in fixed time slots. The host opens each round with a low Start pulse. It then walks through seventeen slots of three clocks each. The first sixteen slots carry interrupt lines 0 to 15 and the seventeenth carries the I/O check flag. The host closes the round with a Stop pulse, and the width of that pulse tells every agent whether the next round runs back to back or waits for a request.

In continuous operation the host opens a new round as soon as the previous one is over. In quiet operation the wire rests high until a peripheral pulls it low for one clock. The host sees this and carries on driving the pulse low until the Start pulse has its programmed width. The captured slot values are gathered into a shadow register and handed to the outputs all at once when the round closes. Downstream logic therefore never sees a vector that mixes two rounds.

Top module: `sirq_host`

## Requirements
- R1: A Start pulse driven by the host holds the wire low for `start_len` clocks when that input lies in 4..8. Smaller values give 4 clocks and larger values give 8. The value is taken when the pulse begins.
- R2: Every low pulse the host drives is followed by exactly one clock of driving high (`sirq_oe`=1, `sirq_do`=1). The host then releases the wire (`sirq_oe`=0) for one clock.
- R3: After the Start turn-around come 17 slots of three clocks each: sample, recovery and turn-around. The host never drives during any of them. The wire is sampled in the sample clock of slot k, where slot k carries `irq_vec[k]` for k = 0..15 and slot 16 carries `io_check`.
- R4: A high sample gives 1 (asserted) and a low sample gives 0. `irq_vec` and `io_check` change only on the clock that enters the Stop pulse, all bits together. Up to that clock they keep the previous round's values.
- R5: The Stop pulse is 2 clocks low when `mode_quiet` is 1 at the end of the last slot, and 3 clocks low when it is 0. It is then followed by the recovery and release of R2.
- R6: After a 3-clock Stop, the next Start pulse begins on the clock right after the Stop turn-around.
- R7: After a 2-clock Stop, the host leaves the wire released for as long as the wire stays high. When a peripheral pulls the wire low for one clock, the host drives it low from the next clock on, so the total low time equals the R1 width.
- R8: While reset is held, `sirq_oe`, `irq_vec` and `io_check` are 0. The first round after reset starts by itself and ends with a 3-clock Stop whatever `mode_quiet` says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_quiet | input | 1 | 1 asks for quiet operation after the current round |
| start_len | input | LEN_W (4) | Requested Start pulse width in clocks |
| sirq_di | input | 1 | Resolved level of the shared wire |
| sirq_oe | output | 1 | Host drives the wire when 1 |
| sirq_do | output | 1 | Level driven while `sirq_oe` is 1 |
| irq_vec | output | NUM_IRQ (16) | Interrupt levels of the last finished round |
| io_check | output | 1 | I/O check flag of the last finished round |

## Verification
The assertions take for granted that the wire is resolved correctly outside the block. A peripheral only ever pulls it low, and only during a sample clock or as a one-clock quiet request. They also assume `start_len` stays at or below the largest supported width once it has been clamped. The stimulus models the wire as the host's drive when enabled, and otherwise as the pull-up level unless the bench peripheral pulls low. The bench changes `start_len` and `mode_quiet` only while slots are in progress, well before the clock that latches them.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_START,
      ST_START_R,
      ST_START_T,
      ST_SLOT_S,
      ST_SLOT_R,
      ST_SLOT_T,
      ST_STOP,
      ST_STOP_R,
      ST_STOP_T
   } sirq_state_e;

   localparam int QUIET_STOP_CLKS = 2;
   localparam int CONT_STOP_CLKS  = 3;

endpackage

// File: rtl/sirq_len_sel.sv
module sirq_len_sel #(
   parameter int LEN_W     = 4,
   parameter int MIN_START = 4,
   parameter int MAX_START = 8
) (
   input  logic [LEN_W-1:0] raw_len,
   output logic [LEN_W-1:0] eff_len
);

   localparam logic [LEN_W-1:0] LO = LEN_W'(MIN_START);
   localparam logic [LEN_W-1:0] HI = LEN_W'(MAX_START);

   always_comb begin
      if (raw_len < LO)
         eff_len = LO;
      else if (raw_len > HI)
         eff_len = HI;
      else
         eff_len = raw_len;
   end

endmodule

// File: rtl/sirq_seq.sv
module sirq_seq
   import sirq_pkg::*;
#(
   parameter int NUM_SLOTS = 17,
   parameter int LEN_W     = 4,
   parameter int SLOT_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_quiet,
   input  logic [LEN_W-1:0]  eff_len,
   input  logic              line_in,
   output logic              drv_en,
   output logic              drv_val,
   output logic              sample_en,
   output logic [SLOT_W-1:0] sample_idx,
   output logic              vec_load,
   output logic              in_slot
);

   localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(NUM_SLOTS - 1);
   localparam logic [LEN_W-1:0]  QSTOP_LAST = LEN_W'(QUIET_STOP_CLKS - 1);
   localparam logic [LEN_W-1:0]  CSTOP_LAST = LEN_W'(CONT_STOP_CLKS - 1);

   sirq_state_e       state_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [LEN_W-1:0]  len_q;
   logic [SLOT_W-1:0] slot_q;
   logic              stop_quiet_q;
   logic              quiet_idle_q;
   logic              first_round_q;
   logic [LEN_W-1:0]  stop_last;

   assign stop_last = stop_quiet_q ? QSTOP_LAST : CSTOP_LAST;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         cnt_q         <= '0;
         len_q         <= '0;
         slot_q        <= '0;
         stop_quiet_q  <= 1'b0;
         quiet_idle_q  <= 1'b0;
         first_round_q <= 1'b1;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (!quiet_idle_q) begin
                  state_q <= ST_START;
                  cnt_q   <= '0;
                  len_q   <= eff_len;
               end else if (!line_in) begin
                  // a peripheral already supplied the first low clock
                  state_q <= ST_START;
                  cnt_q   <= LEN_W'(1);
                  len_q   <= eff_len;
               end
            end
            ST_START: begin
               if (cnt_q == len_q - 1'b1)
                  state_q <= ST_START_R;
               else
                  cnt_q <= cnt_q + 1'b1;
            end
            ST_START_R: state_q <= ST_START_T;
            ST_START_T: begin
               state_q <= ST_SLOT_S;
               slot_q  <= '0;
            end
            ST_SLOT_S: state_q <= ST_SLOT_R;
            ST_SLOT_R: state_q <= ST_SLOT_T;
            ST_SLOT_T: begin
               if (slot_q == LAST_SLOT) begin
                  state_q      <= ST_STOP;
                  cnt_q        <= '0;
                  stop_quiet_q <= mode_quiet && !first_round_q;
               end else begin
                  state_q <= ST_SLOT_S;
                  slot_q  <= slot_q + 1'b1;
               end
            end
            ST_STOP: begin
               if (cnt_q == stop_last)
                  state_q <= ST_STOP_R;
               else
                  cnt_q <= cnt_q + 1'b1;
            end
            ST_STOP_R: state_q <= ST_STOP_T;
            ST_STOP_T: begin
               first_round_q <= 1'b0;
               if (stop_quiet_q) begin
                  quiet_idle_q <= 1'b1;
                  state_q      <= ST_IDLE;
               end else begin
                  quiet_idle_q <= 1'b0;
                  state_q      <= ST_START;
                  cnt_q        <= '0;
                  len_q        <= eff_len;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      drv_en  = (state_q == ST_START) || (state_q == ST_START_R) ||
                (state_q == ST_STOP)  || (state_q == ST_STOP_R);
      drv_val = (state_q == ST_START_R) || (state_q == ST_STOP_R);
   end

   assign sample_en  = (state_q == ST_SLOT_S);
   assign sample_idx = slot_q;
   assign vec_load   = (state_q == ST_SLOT_T) && (slot_q == LAST_SLOT);
   assign in_slot    = (state_q == ST_SLOT_S) || (state_q == ST_SLOT_R) ||
                       (state_q == ST_SLOT_T);

endmodule

// File: rtl/sirq_capture.sv
module sirq_capture #(
   parameter int NUM_IRQ = 16,
   parameter int SLOT_W  = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sample_en,
   input  logic [SLOT_W-1:0]  sample_idx,
   input  logic               line_in,
   input  logic               vec_load,
   output logic [NUM_IRQ-1:0] irq_vec,
   output logic               io_check
);

   localparam int NUM_SLOTS = NUM_IRQ + 1;

   logic [NUM_SLOTS-1:0] shadow_q;

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            shadow_q[g] <= 1'b0;
         else if (sample_en && (sample_idx == SLOT_W'(g)))
            shadow_q[g] <= line_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_vec  <= '0;
         io_check <= 1'b0;
      end else if (vec_load) begin
         irq_vec  <= shadow_q[NUM_IRQ-1:0];
         io_check <= shadow_q[NUM_IRQ];
      end
   end

endmodule

// File: rtl/sirq_host.sv
module sirq_host #(
   parameter int NUM_IRQ   = 16,
   parameter int LEN_W     = 4,
   parameter int MIN_START = 4,
   parameter int MAX_START = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_quiet,
   input  logic [LEN_W-1:0]   start_len,
   input  logic               sirq_di,
   output logic               sirq_oe,
   output logic               sirq_do,
   output logic [NUM_IRQ-1:0] irq_vec,
   output logic               io_check
);

   localparam int NUM_SLOTS = NUM_IRQ + 1;
   localparam int SLOT_W    = $clog2(NUM_SLOTS);

   initial begin
      assert (MIN_START >= 2 && MAX_START >= MIN_START && MAX_START < (1 << LEN_W))
         else $error("sirq_host: start width range does not fit LEN_W");
      assert (NUM_IRQ >= 1)
         else $error("sirq_host: NUM_IRQ must be at least 1");
   end

   logic [LEN_W-1:0]  eff_len;
   logic              sample_en;
   logic [SLOT_W-1:0] sample_idx;
   logic              vec_load;
   logic              in_slot;

   sirq_len_sel #(
      .LEN_W    (LEN_W),
      .MIN_START(MIN_START),
      .MAX_START(MAX_START)
   ) u_len (
      .raw_len(start_len),
      .eff_len(eff_len)
   );

   sirq_seq #(
      .NUM_SLOTS(NUM_SLOTS),
      .LEN_W    (LEN_W),
      .SLOT_W   (SLOT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_quiet(mode_quiet),
      .eff_len   (eff_len),
      .line_in   (sirq_di),
      .drv_en    (sirq_oe),
      .drv_val   (sirq_do),
      .sample_en (sample_en),
      .sample_idx(sample_idx),
      .vec_load  (vec_load),
      .in_slot   (in_slot)
   );

   sirq_capture #(
      .NUM_IRQ(NUM_IRQ),
      .SLOT_W (SLOT_W)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_en (sample_en),
      .sample_idx(sample_idx),
      .line_in   (sirq_di),
      .vec_load  (vec_load),
      .irq_vec   (irq_vec),
      .io_check  (io_check)
   );

endmodule

// File: rtl/sirq_host_chk.sv
module sirq_host_chk #(
   parameter int NUM_IRQ   = 16,
   parameter int MAX_START = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sirq_oe,
   input logic               sirq_do,
   input logic [NUM_IRQ-1:0] irq_vec,
   input logic               io_check,
   input logic               vec_load,
   input logic               in_slot
);

   localparam int RUN_W = $clog2(MAX_START + 2);

   logic             host_low;
   logic [RUN_W-1:0] low_run_q;

   assign host_low = sirq_oe && !sirq_do;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_run_q <= '0;
      else if (!host_low)
         low_run_q <= '0;
      else if (low_run_q != '1)
         low_run_q <= low_run_q + 1'b1;
   end

   // R1: no low drive lasts longer than the widest Start pulse
   p_low_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
      low_run_q <= RUN_W'(MAX_START));

   // R2: a host low pulse is followed by a driven-high recovery clock
   p_recover_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(host_low) |-> (sirq_oe && sirq_do));

   // R2: recovery is followed by release
   p_release_after_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sirq_oe && sirq_do) |=> !sirq_oe);

   // R3: host stays off the wire in every slot clock
   p_slot_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_slot |-> !sirq_oe);

   // R4: outputs hold between round ends
   p_vec_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_load |=> ($stable(irq_vec) && $stable(io_check)));

endmodule

bind sirq_host sirq_host_chk #(
   .NUM_IRQ  (NUM_IRQ),
   .MAX_START(MAX_START)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sirq_oe (sirq_oe),
   .sirq_do (sirq_do),
   .irq_vec (irq_vec),
   .io_check(io_check),
   .vec_load(vec_load),
   .in_slot (in_slot)
);

// File: tb/sirq_host_tb_top.sv
module sirq_host_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_quiet = 1'b0;
   logic [3:0]  start_len = 4'd5;
   logic        per_low = 1'b0;
   logic        line;
   logic        sirq_oe;
   logic        sirq_do;
   logic [15:0] irq_vec;
   logic        io_check;

   int          errors = 0;
   int          checks = 0;
   logic [16:0] prev_pat = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // open-drain wire with pull-up
   assign line = sirq_oe ? sirq_do : !per_low;

   sirq_host dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_quiet(mode_quiet),
      .start_len (start_len),
      .sirq_di   (line),
      .sirq_oe   (sirq_oe),
      .sirq_do   (sirq_do),
      .irq_vec   (irq_vec),
      .io_check  (io_check)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic count_low(output int n);
      n = 0;
      while (line == 1'b0 && n < 20) begin
         n++;
         @(negedge clk);
      end
   endtask

   // entered at the first negedge of a host Start pulse
   task automatic start_by_host(input int exp_len);
      int n;
      count_low(n);
      chk(n == exp_len, "R1", "host start width", n, exp_len);
      chk(sirq_oe && sirq_do, "R2", "start recovery drive-high", {sirq_oe, sirq_do}, 3);
      @(negedge clk);
      chk(!sirq_oe, "R2", "start turn-around release", sirq_oe, 0);
   endtask

   // entered at the Stop turn-around negedge after a quiet Stop
   task automatic start_by_periph(input int exp_len);
      int n;
      bit idle_ok = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (sirq_oe || !line) idle_ok = 1'b0;
      end
      chk(idle_ok, "R7", "quiet idle leaves wire released", idle_ok, 1);
      per_low = 1'b1;
      @(negedge clk);
      per_low = 1'b0;
      chk(sirq_oe && !sirq_do, "R7", "host extends peripheral start", {sirq_oe, sirq_do}, 2);
      count_low(n);
      chk(n + 1 == exp_len, "R7", "total quiet start width", n + 1, exp_len);
      chk(sirq_oe && sirq_do, "R2", "start recovery drive-high", {sirq_oe, sirq_do}, 3);
      @(negedge clk);
      chk(!sirq_oe, "R2", "start turn-around release", sirq_oe, 0);
   endtask

   // entered at the Start turn-around negedge; leaves at the Stop turn-around negedge
   task automatic run_slots(input logic [16:0] pat, input bit quiet,
                            input logic [3:0] next_len, input int exp_stop,
                            input string stop_req);
      bit slot_ok = 1'b1;
      int n;
      mode_quiet = quiet;
      start_len  = next_len;
      for (int f = 0; f < 17; f++) begin
         @(negedge clk);
         if (sirq_oe) slot_ok = 1'b0;
         per_low = !pat[f];
         @(negedge clk);
         per_low = 1'b0;
         if (sirq_oe) slot_ok = 1'b0;
         @(negedge clk);
         if (sirq_oe) slot_ok = 1'b0;
      end
      chk(slot_ok, "R3", "host silent in slots", slot_ok, 1);
      chk({io_check, irq_vec} == prev_pat, "R4", "outputs hold before stop",
          int'({io_check, irq_vec}), int'(prev_pat));
      @(negedge clk);
      chk(irq_vec == pat[15:0], "R4", "irq_vec after round", irq_vec, pat[15:0]);
      chk(io_check == pat[16], "R3", "io_check from slot 16", io_check, pat[16]);
      prev_pat = pat;
      count_low(n);
      chk(n == exp_stop, stop_req, "stop width", n, exp_stop);
      chk(sirq_oe && sirq_do, "R5", "stop recovery drive-high", {sirq_oe, sirq_do}, 3);
      @(negedge clk);
      chk(!sirq_oe, "R5", "stop turn-around release", sirq_oe, 0);
   endtask

   task automatic expect_back_to_back();
      @(negedge clk);
      chk(line == 1'b0 && sirq_oe, "R6", "start right after stop turn-around",
          {line, sirq_oe}, 1);
   endtask

   task automatic test_reset_and_first();
      mode_quiet = 1'b1;
      start_len  = 4'd5;
      repeat (3) @(negedge clk);
      chk(!sirq_oe, "R8", "oe in reset", sirq_oe, 0);
      chk(irq_vec == 16'h0 && !io_check, "R8", "outputs in reset",
          int'({io_check, irq_vec}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(line == 1'b0, "R8", "first round starts by itself", line, 0);
      start_by_host(5);
      run_slots(17'h1_A5C3, 1'b1, 4'd2, 3, "R8");
   endtask

   task automatic test_cont_clamp_low();
      expect_back_to_back();
      start_by_host(4);
      run_slots(17'h0_FFFF, 1'b0, 4'd12, 3, "R5");
   endtask

   task automatic test_cont_clamp_high();
      expect_back_to_back();
      start_by_host(8);
      run_slots(17'h1_0000, 1'b1, 4'd6, 2, "R5");
   endtask

   task automatic test_quiet_rounds();
      start_by_periph(6);
      run_slots(17'h0_0001, 1'b1, 4'd7, 2, "R5");
      start_by_periph(7);
      run_slots(17'h1_8000, 1'b0, 4'd8, 3, "R5");
   endtask

   task automatic test_back_to_continuous();
      expect_back_to_back();
      start_by_host(8);
      run_slots(17'h0_5A5A, 1'b0, 4'd4, 3, "R5");
   endtask

   initial begin
      test_reset_and_first();
      test_cont_clamp_low();
      test_cont_clamp_high();
      test_quiet_rounds();
      test_back_to_continuous();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule